// File: doc/BRIEF.md
# CAN Node Error-State Monitor

This block sits next to the fault-confinement counters of a CAN controller. It samples the transmit error count (nine bits, so that counts above 255 can be shown) and the receive error count every clock. From them it derives level flags for the warning, error-passive and bus-off conditions, together with one encoded node state. It also keeps a sticky overflow flag for each receive buffer. A buffer raises its overflow flag when a message has passed acceptance but that buffer is still occupied.

A single sticky error interrupt flag gathers the events that need the host's attention. It is raised by any overflow event and by any change of the transmit-side or receive-side error level, whether the level rises or falls. The interrupt flag and each overflow flag stay set until the host pulses the matching clear input. A set condition in the same cycle as a clear takes precedence over the clear. All outputs are registered and follow the inputs with one clock of latency.

Top module: `can_err_monitor`

## Requirements
- R1: `rx_warn` is 1 in the cycle after `rx_err_cnt` was at or above 96, and 0 in the cycle after it was below 96.
- R2: `tx_warn` is 1 in the cycle after `tx_err_cnt` was at or above 96, and 0 in the cycle after it was below 96.
- R3: `rx_passive` (and likewise `tx_passive`) is 1 in the cycle after its counter was above 127, and 0 otherwise. A count of exactly 127 is not passive.
- R4: `bus_off` is 1 in the cycle after `tx_err_cnt` was above 255, and 0 otherwise. A count of 255 is not bus-off.
- R5: `node_state` encodes 0 = active, 1 = warning, 2 = passive, 3 = bus-off. It shows the most severe condition of the two sides, so bus-off beats passive and passive beats warning.
- R6: bit i of `rx_ovfl` (bit 0 = buffer 0) is 1 in the cycle after `rx_ovfl_evt[i]`. It then stays 1 until a cycle with `rx_ovfl_clr[i]` and no event. An event and a clear in the same cycle leave the bit set.
- R7: a clear on one buffer's overflow flag leaves every other buffer's flag unchanged.
- R8: `err_irq` is 1 in the cycle after any bit of `rx_ovfl_evt` was high.
- R9: `err_irq` is set in the cycle after the transmit or receive level (active, warning, passive, bus-off) changed in either direction. A counter change that stays within the same level does not set it.
- R10: `err_irq` stays 1 until `irq_clr` is pulsed. If a set condition is present in the same cycle as `irq_clr`, the flag stays 1.
- R11: while `rst_n` is low, every flag output is 0 and `node_state` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | TX_CNT_W (9) | Transmit error count |
| rx_err_cnt | input | RX_CNT_W (8) | Receive error count |
| rx_ovfl_evt | input | NUM_RXBUF (2) | Per-buffer overflow event pulse |
| rx_ovfl_clr | input | NUM_RXBUF (2) | Per-buffer host clear of the overflow flag |
| irq_clr | input | 1 | Host clear of the error interrupt flag |
| tx_warn | output | 1 | Transmit warning level |
| rx_warn | output | 1 | Receive warning level |
| tx_passive | output | 1 | Transmit error-passive level |
| rx_passive | output | 1 | Receive error-passive level |
| bus_off | output | 1 | Bus-off level |
| node_state | output | 2 | Encoded node error state |
| rx_ovfl | output | NUM_RXBUF (2) | Sticky per-buffer overflow flags |
| err_irq | output | 1 | Sticky error interrupt flag |

## Verification
Two kinds of collision are exercised. In the first, a set cause for the interrupt (a level change or an overflow event) arrives in the same cycle as the host's `irq_clr`. In the second, an overflow event on a buffer coincides with that buffer's own clear, or with a clear of a different buffer. The stimulus table places these on purpose, for example a rise of the receive count to 96 together with `irq_clr`, or a fall from passive to active together with `irq_clr`. A flag is judged correct only if it reads 1 in the following cycle, and only if a later clear with no cause present then drops it to 0.

// File: rtl/can_esm_pkg.sv
package can_esm_pkg;

    // Ordered by severity so that precedence is a plain maximum.
    typedef enum logic [1:0] {
        LVL_ACTIVE  = 2'd0,
        LVL_WARN    = 2'd1,
        LVL_PASSIVE = 2'd2,
        LVL_BUSOFF  = 2'd3
    } err_lvl_e;

    typedef struct packed {
        err_lvl_e tx_lvl;
        err_lvl_e rx_lvl;
        err_lvl_e node;
        logic     irq;
    } mon_state_t;

    function automatic err_lvl_e lvl_max(input err_lvl_e a, input err_lvl_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/can_esm_level.sv
module can_esm_level
    import can_esm_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255,
    parameter bit HAS_BUSOFF    = 1'b0
) (
    input  logic [CNT_W-1:0] cnt,
    output err_lvl_e         lvl
);

    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] WARN_AT    = CW'(WARN_LIMIT);
    localparam logic [CW-1:0] PASS_ABOVE = CW'(PASSIVE_LIMIT);

    logic [CW-1:0] cnt_x;
    logic          over_bo;
    logic          over_pass;
    logic          at_warn;

    assign cnt_x     = {1'b0, cnt};
    assign over_pass = cnt_x > PASS_ABOVE;
    assign at_warn   = cnt_x >= WARN_AT;

    generate
        if (HAS_BUSOFF) begin : g_bo
            localparam logic [CW-1:0] BO_ABOVE = CW'(BUSOFF_LIMIT);
            assign over_bo = cnt_x > BO_ABOVE;
        end else begin : g_nobo
            assign over_bo = 1'b0;
        end
    endgenerate

    always_comb begin
        if (over_bo)        lvl = LVL_BUSOFF;
        else if (over_pass) lvl = LVL_PASSIVE;
        else if (at_warn)   lvl = LVL_WARN;
        else                lvl = LVL_ACTIVE;
    end

endmodule

// File: rtl/can_esm_sticky.sv
module can_esm_sticky #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    output logic [NUM_FLAGS-1:0] flag_o
);

    logic [NUM_FLAGS-1:0] flag_d;
    logic [NUM_FLAGS-1:0] flag_q;

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
            always_comb begin
                flag_d[i] = flag_q[i];
                if (set_i[i])      flag_d[i] = 1'b1;
                else if (clr_i[i]) flag_d[i] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/can_err_monitor.sv
module can_err_monitor
    import can_esm_pkg::*;
#(
    parameter int TX_CNT_W      = 9,
    parameter int RX_CNT_W      = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255,
    parameter int NUM_RXBUF     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TX_CNT_W-1:0]  tx_err_cnt,
    input  logic [RX_CNT_W-1:0]  rx_err_cnt,
    input  logic [NUM_RXBUF-1:0] rx_ovfl_evt,
    input  logic [NUM_RXBUF-1:0] rx_ovfl_clr,
    input  logic                 irq_clr,
    output logic                 tx_warn,
    output logic                 rx_warn,
    output logic                 tx_passive,
    output logic                 rx_passive,
    output logic                 bus_off,
    output logic [1:0]           node_state,
    output logic [NUM_RXBUF-1:0] rx_ovfl,
    output logic                 err_irq
);

    err_lvl_e   tx_lvl_now;
    err_lvl_e   rx_lvl_now;
    mon_state_t st_d;
    mon_state_t st_q;
    logic       lvl_chg;
    logic       ovf_any;

    can_esm_level #(
        .CNT_W        (TX_CNT_W),
        .WARN_LIMIT   (WARN_LIMIT),
        .PASSIVE_LIMIT(PASSIVE_LIMIT),
        .BUSOFF_LIMIT (BUSOFF_LIMIT),
        .HAS_BUSOFF   (1'b1)
    ) u_tx_lvl (
        .cnt(tx_err_cnt),
        .lvl(tx_lvl_now)
    );

    can_esm_level #(
        .CNT_W        (RX_CNT_W),
        .WARN_LIMIT   (WARN_LIMIT),
        .PASSIVE_LIMIT(PASSIVE_LIMIT),
        .BUSOFF_LIMIT (BUSOFF_LIMIT),
        .HAS_BUSOFF   (1'b0)
    ) u_rx_lvl (
        .cnt(rx_err_cnt),
        .lvl(rx_lvl_now)
    );

    can_esm_sticky #(
        .NUM_FLAGS(NUM_RXBUF)
    ) u_ovfl (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (rx_ovfl_evt),
        .clr_i (rx_ovfl_clr),
        .flag_o(rx_ovfl)
    );

    always_comb begin
        st_d        = st_q;
        st_d.tx_lvl = tx_lvl_now;
        st_d.rx_lvl = rx_lvl_now;
        st_d.node   = lvl_max(tx_lvl_now, rx_lvl_now);
        lvl_chg     = (tx_lvl_now != st_q.tx_lvl) || (rx_lvl_now != st_q.rx_lvl);
        ovf_any     = |rx_ovfl_evt;
        if (lvl_chg || ovf_any) st_d.irq = 1'b1;
        else if (irq_clr)       st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tx_lvl <= LVL_ACTIVE;
            st_q.rx_lvl <= LVL_ACTIVE;
            st_q.node   <= LVL_ACTIVE;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_warn    = st_q.tx_lvl != LVL_ACTIVE;
    assign rx_warn    = st_q.rx_lvl != LVL_ACTIVE;
    assign tx_passive = st_q.tx_lvl >= LVL_PASSIVE;
    assign rx_passive = st_q.rx_lvl >= LVL_PASSIVE;
    assign bus_off    = st_q.tx_lvl == LVL_BUSOFF;
    assign node_state = st_q.node;
    assign err_irq    = st_q.irq;

endmodule

// File: rtl/can_err_monitor_chk.sv
module can_err_monitor_chk #(
    parameter int TX_CNT_W      = 9,
    parameter int RX_CNT_W      = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255,
    parameter int NUM_RXBUF     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [TX_CNT_W-1:0]  tx_err_cnt,
    input logic [RX_CNT_W-1:0]  rx_err_cnt,
    input logic [NUM_RXBUF-1:0] rx_ovfl_evt,
    input logic [NUM_RXBUF-1:0] rx_ovfl_clr,
    input logic                 irq_clr,
    input logic                 tx_warn,
    input logic                 rx_warn,
    input logic                 tx_passive,
    input logic                 rx_passive,
    input logic                 bus_off,
    input logic [1:0]           node_state,
    input logic [NUM_RXBUF-1:0] rx_ovfl,
    input logic                 err_irq
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1
    a_r1_rx_warn: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rx_warn == (32'($past(rx_err_cnt)) >= WARN_LIMIT)));
    // R2
    a_r2_tx_warn: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (tx_warn == (32'($past(tx_err_cnt)) >= WARN_LIMIT)));
    // R3
    a_r3_tx_passive: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (tx_passive == (32'($past(tx_err_cnt)) > PASSIVE_LIMIT)));
    a_r3_rx_passive: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rx_passive == (32'($past(rx_err_cnt)) > PASSIVE_LIMIT)));
    // R4
    a_r4_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (bus_off == (32'($past(tx_err_cnt)) > BUSOFF_LIMIT)));
    // R5
    a_r5_busoff_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> (node_state == 2'd3));
    a_r5_passive_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && (tx_passive || rx_passive)) |-> (node_state == 2'd2));
    // R9
    a_r9_change_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (node_state != $past(node_state))) |-> err_irq);
    // R8
    a_r8_ovfl_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(|rx_ovfl_evt)) |-> err_irq);
    // R10
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(err_irq) && !$past(irq_clr)) |-> err_irq);

    generate
        for (genvar i = 0; i < NUM_RXBUF; i++) begin : g_buf
            // R6
            a_r6_ovfl_set: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && $past(rx_ovfl_evt[i])) |-> rx_ovfl[i]);
            a_r6_ovfl_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && $past(rx_ovfl[i]) && !$past(rx_ovfl_clr[i])) |-> rx_ovfl[i]);
        end
    endgenerate

endmodule

bind can_err_monitor can_err_monitor_chk #(
    .TX_CNT_W     (TX_CNT_W),
    .RX_CNT_W     (RX_CNT_W),
    .WARN_LIMIT   (WARN_LIMIT),
    .PASSIVE_LIMIT(PASSIVE_LIMIT),
    .BUSOFF_LIMIT (BUSOFF_LIMIT),
    .NUM_RXBUF    (NUM_RXBUF)
) u_chk (.*);

// File: tb/can_err_monitor_tb_top.sv
module can_err_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tx_err_cnt = '0;
    logic [7:0] rx_err_cnt = '0;
    logic [1:0] rx_ovfl_evt = '0;
    logic [1:0] rx_ovfl_clr = '0;
    logic       irq_clr = 1'b0;
    logic       tx_warn, rx_warn, tx_passive, rx_passive, bus_off, err_irq;
    logic [1:0] node_state;
    logic [1:0] rx_ovfl;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    can_err_monitor dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_err_cnt (tx_err_cnt),
        .rx_err_cnt (rx_err_cnt),
        .rx_ovfl_evt(rx_ovfl_evt),
        .rx_ovfl_clr(rx_ovfl_clr),
        .irq_clr    (irq_clr),
        .tx_warn    (tx_warn),
        .rx_warn    (rx_warn),
        .tx_passive (tx_passive),
        .rx_passive (rx_passive),
        .bus_off    (bus_off),
        .node_state (node_state),
        .rx_ovfl    (rx_ovfl),
        .err_irq    (err_irq)
    );

    // Row: {tx, rx, evt, oclr, iclr, exp_state, exp{txw,rxw,txp,rxp,bo}, exp_ovfl, exp_irq}
    localparam int NV = 22;
    localparam logic [31:0] VEC [NV] = '{
        {9'd10,  8'd5,   2'b00, 2'b00, 1'b0, 2'd0, 5'b00000, 2'b00, 1'b0},
        {9'd95,  8'd95,  2'b00, 2'b00, 1'b0, 2'd0, 5'b00000, 2'b00, 1'b0},
        {9'd96,  8'd95,  2'b00, 2'b00, 1'b0, 2'd1, 5'b10000, 2'b00, 1'b1},
        {9'd96,  8'd96,  2'b00, 2'b00, 1'b1, 2'd1, 5'b11000, 2'b00, 1'b1},
        {9'd100, 8'd100, 2'b00, 2'b00, 1'b1, 2'd1, 5'b11000, 2'b00, 1'b0},
        {9'd127, 8'd128, 2'b00, 2'b00, 1'b0, 2'd2, 5'b11010, 2'b00, 1'b1},
        {9'd128, 8'd128, 2'b00, 2'b00, 1'b1, 2'd2, 5'b11110, 2'b00, 1'b1},
        {9'd200, 8'd200, 2'b00, 2'b00, 1'b1, 2'd2, 5'b11110, 2'b00, 1'b0},
        {9'd255, 8'd255, 2'b00, 2'b00, 1'b0, 2'd2, 5'b11110, 2'b00, 1'b0},
        {9'd256, 8'd255, 2'b00, 2'b00, 1'b0, 2'd3, 5'b11111, 2'b00, 1'b1},
        {9'd256, 8'd0,   2'b00, 2'b00, 1'b1, 2'd3, 5'b10101, 2'b00, 1'b1},
        {9'd0,   8'd0,   2'b00, 2'b00, 1'b1, 2'd0, 5'b00000, 2'b00, 1'b1},
        {9'd0,   8'd0,   2'b00, 2'b00, 1'b1, 2'd0, 5'b00000, 2'b00, 1'b0},
        {9'd0,   8'd0,   2'b01, 2'b00, 1'b0, 2'd0, 5'b00000, 2'b01, 1'b1},
        {9'd0,   8'd0,   2'b00, 2'b00, 1'b1, 2'd0, 5'b00000, 2'b01, 1'b0},
        {9'd0,   8'd0,   2'b10, 2'b01, 1'b0, 2'd0, 5'b00000, 2'b10, 1'b1},
        {9'd0,   8'd0,   2'b10, 2'b10, 1'b1, 2'd0, 5'b00000, 2'b10, 1'b1},
        {9'd0,   8'd0,   2'b00, 2'b10, 1'b0, 2'd0, 5'b00000, 2'b00, 1'b1},
        {9'd0,   8'd0,   2'b00, 2'b00, 1'b1, 2'd0, 5'b00000, 2'b00, 1'b0},
        {9'd300, 8'd50,  2'b00, 2'b00, 1'b0, 2'd3, 5'b10101, 2'b00, 1'b1},
        {9'd0,   8'd110, 2'b00, 2'b00, 1'b1, 2'd1, 5'b01000, 2'b00, 1'b1},
        {9'd0,   8'd110, 2'b00, 2'b00, 1'b1, 2'd1, 5'b01000, 2'b00, 1'b0}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        #35;
        check("R11", "node_state", int'(node_state), 0);
        check("R11", "flags", int'({tx_warn, rx_warn, tx_passive, rx_passive, bus_off, err_irq}), 0);
        check("R11", "rx_ovfl", int'(rx_ovfl), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        for (int k = 0; k < NV; k++) begin
            logic [31:0] v;
            v = VEC[k];
            tx_err_cnt  = v[31:23];
            rx_err_cnt  = v[22:15];
            rx_ovfl_evt = v[14:13];
            rx_ovfl_clr = v[12:11];
            irq_clr     = v[10];
            step();
            check("R5", "node_state", int'(node_state), int'(v[9:8]));
            check("R2", "tx_warn", int'(tx_warn), int'(v[7]));
            check("R1", "rx_warn", int'(rx_warn), int'(v[6]));
            check("R3", "tx_passive", int'(tx_passive), int'(v[5]));
            check("R3", "rx_passive", int'(rx_passive), int'(v[4]));
            check("R4", "bus_off", int'(bus_off), int'(v[3]));
            check("R6", "rx_ovfl", int'(rx_ovfl), int'(v[2:1]));
            check("R9", "err_irq", int'(err_irq), int'(v[0]));
        end

        // R8: overflow event on buffer 1 alone raises the interrupt
        rx_ovfl_evt = 2'b10; rx_ovfl_clr = 2'b00; irq_clr = 1'b0;
        step();
        check("R8", "err_irq", int'(err_irq), 1);
        // R10: clear with no cause drops the flag
        rx_ovfl_evt = 2'b01; irq_clr = 1'b0;
        step();
        rx_ovfl_evt = 2'b00; irq_clr = 1'b1;
        step();
        check("R10", "err_irq", int'(err_irq), 0);
        // R7: clearing buffer 0 keeps buffer 1
        irq_clr = 1'b0; rx_ovfl_clr = 2'b01;
        step();
        check("R7", "rx_ovfl", int'(rx_ovfl), 2);
        // R10: level fall together with irq_clr keeps the flag
        rx_ovfl_clr = 2'b00; rx_err_cnt = 8'd20; irq_clr = 1'b1;
        step();
        check("R10", "err_irq", int'(err_irq), 1);
        check("R1", "rx_warn", int'(rx_warn), 0);
        irq_clr = 1'b0;
        step();
        check("R10", "err_irq", int'(err_irq), 1);

        // R11: asynchronous reset in mid-run
        tx_err_cnt = 9'd400;
        step();
        rst_n = 1'b0;
        #3;
        check("R11", "node_state", int'(node_state), 0);
        check("R11", "flags", int'({tx_warn, rx_warn, tx_passive, rx_passive, bus_off, err_irq}), 0);
        check("R11", "rx_ovfl", int'(rx_ovfl), 0);
        tx_err_cnt = '0; rx_err_cnt = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R9", "err_irq", int'(err_irq), 0);

        finish_run();
    end

endmodule